// File: doc/BRIEF.md
# Sample-Rate Timing Select Divider

This block produces the input-side and output-side sample timing strobes for two sample-rate converter channels. Each channel owns one 16-bit half of a shared 32-bit select word, with one word for the input side and one for the output side, which gives four independent timing lanes. A select half names a timing source and a divide-ratio index. A clock source is one of three external strobe inputs or one of two baud-rate generator strobes. The lane counts that source's strobes and emits one tick after every full period of the selected ratio. The source can instead be a serial-port word-select strobe, which is forwarded to the lane output without division.

The divide ratios do not follow a linear count. The first three indices give 2, 4 and 6. The ratios then climb from 8, alternately multiplied by 3/2 and by 4/3, up to 49152. The last legal index jumps to 98304. Each clock source has its own enable bit, and a lane's divider only advances while the enable bit of its source is set. All inputs are single-cycle strobes in the block's clock domain.

Top module: `rate_timing_sel`

## Requirements
- R1: While `rstN` is low, all four tick outputs are low. After reset, a divider lane counts from zero, so its first tick needs a full period of source strobes.
- R2: Bits [15:0] of `selIn` control `tickIn[0]` and bits [31:16] control `tickIn[1]`. `selOut` controls `tickOut[0]` and `tickOut[1]` in the same way.
- R3: Source code bits [11:8] of a select half choose the counted strobe: 0 is `srcStrobe[0]`, 1 is `srcStrobe[1]`, 2 is `srcStrobe[2]`, 3 is `brgStrobe[0]` and 4 is `brgStrobe[1]`. Strobes from any other source do not advance the lane.
- R4: Index bits [4:0] pick the ratio. Indices 0, 1 and 2 give 2, 4 and 6. Odd index i from 3 to 27 gives 8·2^((i-3)/2). Even index i from 4 to 28 gives 12·2^((i-4)/2). Index 29 gives 98304. A lane ticks on every ratio-th counted strobe.
- R5: With a clock source code (0 to 4) and index 30 or 31, the lane output stays low.
- R6: Source codes 6 to 15 forward `wsStrobe[code-6]` to the lane output one cycle later, regardless of `divEn`. Source code 5 keeps the output low.
- R7: The enable for clock source code s is `divEn[s+1]`. While that bit is low, strobes of the source are not counted and the partial count is held.
- R8: When the meaningful select bits (mask 0x0F1F) of a half change, that lane's count restarts at zero. The output is low in the following cycle, and a strobe arriving in the cycle of the change is not counted. Bits outside 0x0F1F have no effect.
- R9: A tick is high for exactly one cycle. It appears in the cycle after the strobe that completes the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selIn | input | 32 | Input-side select word; even channel in [15:0], odd channel in [31:16] |
| selOut | input | 32 | Output-side select word, same layout as `selIn` |
| srcStrobe | input | 3 | External clock source strobes, codes 0 to 2 |
| brgStrobe | input | 2 | Baud-rate generator strobes, codes 3 and 4 |
| wsStrobe | input | 10 | Word-select strobes by slot, reached through codes 6 to 15 |
| divEn | input | 5 | Divider enables, bit s+1 for source code s (range [5:1]) |
| tickIn | output | 2 | Input-side timing ticks per channel |
| tickOut | output | 2 | Output-side timing ticks per channel |

## Verification
The hardest conditions to reach are the long periods: index 29 needs 98304 counted strobes before its single tick can be seen. The stimulus sets all four lanes to different indices while one shared strobe runs. This sweeps the whole ratio table, including the reserved indices, in a few batches that are each only as long as the longest ratio in the batch.

A second hard case is a select change that arrives in the same cycle as a counted strobe. Directed steps create this case, together with writes that touch only the masked-out bits. Randomized phases then mix source codes, enable patterns and word-select codes against a reference lane model in the bench.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  localparam int CNT_W    = 17;           // holds the largest ratio, 98304
  localparam int NUM_IDX  = 30;           // legal ratio indices 0..29
  localparam int WS_BASE  = 6;            // first word-select source code
  localparam logic [15:0] SEL_MASK = 16'h0F1F;

  // Control-to-datapath strobes for one lane
  typedef struct packed {
    logic             restart;
    logic             step;
    logic             pass;
    logic [CNT_W-1:0] lastCount;
  } laneCmd_t;

  // Divide ratio for a ratio index; zero for reserved indices
  function automatic logic [CNT_W-1:0] ratioOf(input logic [4:0] idx);
    int r;
    if (idx < 5'd3)        r = 2 * (int'(idx) + 1);
    else if (idx == 5'd29) r = 98304;
    else if (idx > 5'd29)  r = 0;
    else if (idx[0])       r = 8 << ((int'(idx) - 3) / 2);
    else                   r = 12 << ((int'(idx) - 4) / 2);
    return r[CNT_W-1:0];
  endfunction

endpackage

// File: rtl/tsel_ctrl.sv
module tsel_ctrl
  import tsel_pkg::*;
#(
  parameter int NUM_EXT = 3,
  parameter int NUM_BRG = 2,
  parameter int NUM_WS  = 10,
  parameter int HALF_W  = 16
) (
  input  logic                       clk,
  input  logic [HALF_W-1:0]          sel,
  input  logic [NUM_EXT-1:0]         srcStrobe,
  input  logic [NUM_BRG-1:0]         brgStrobe,
  input  logic [NUM_WS-1:0]          wsStrobe,
  input  logic [NUM_EXT+NUM_BRG:1]   divEn,
  output laneCmd_t                   cmd
);

  localparam int NUM_CLK = NUM_EXT + NUM_BRG;

  logic [HALF_W-1:0]  selMasked;
  logic [HALF_W-1:0]  selQ;
  logic [3:0]         srcCode;
  logic [4:0]         ratioIdx;
  logic [NUM_CLK-1:0] clkVec;
  logic               stepNow;
  logic               passNow;

  assign selMasked = sel & SEL_MASK;
  assign srcCode   = selMasked[11:8];
  assign ratioIdx  = selMasked[4:0];
  assign clkVec    = {brgStrobe, srcStrobe};

  // Previous select, captured every cycle (also during reset)
  always_ff @(posedge clk) begin
    selQ <= selMasked;
  end

  always_comb begin
    stepNow = 1'b0;
    for (int s = 0; s < NUM_CLK; s++) begin
      if (int'(srcCode) == s) stepNow = clkVec[s] & divEn[s+1];
    end
    passNow = 1'b0;
    for (int w = 0; w < NUM_WS; w++) begin
      if (int'(srcCode) == WS_BASE + w) passNow = wsStrobe[w];
    end
  end

  always_comb begin
    cmd.restart   = (selMasked != selQ);
    cmd.step      = stepNow && (int'(ratioIdx) < NUM_IDX);
    cmd.pass      = passNow;
    cmd.lastCount = ratioOf(ratioIdx) - CNT_W'(1);
  end

endmodule

// File: rtl/tsel_count.sv
module tsel_count
  import tsel_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  laneCmd_t cmd,
  output logic     tick
);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      tick  <= 1'b0;
    end else if (cmd.restart) begin
      count <= '0;
      tick  <= 1'b0;
    end else if (cmd.step) begin
      if (count == cmd.lastCount) begin
        count <= '0;
        tick  <= 1'b1;
      end else begin
        count <= count + CNT_W'(1);
        tick  <= 1'b0;
      end
    end else begin
      tick <= cmd.pass;
    end
  end

endmodule

// File: rtl/rate_timing_sel.sv
module rate_timing_sel
  import tsel_pkg::*;
#(
  parameter int NUM_EXT = 3,
  parameter int NUM_BRG = 2,
  parameter int NUM_WS  = 10,
  parameter int SEL_W   = 32,
  parameter int HALF_W  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [SEL_W-1:0]           selIn,
  input  logic [SEL_W-1:0]           selOut,
  input  logic [NUM_EXT-1:0]         srcStrobe,
  input  logic [NUM_BRG-1:0]         brgStrobe,
  input  logic [NUM_WS-1:0]          wsStrobe,
  input  logic [NUM_EXT+NUM_BRG:1]   divEn,
  output logic [SEL_W/HALF_W-1:0]    tickIn,
  output logic [SEL_W/HALF_W-1:0]    tickOut
);

  localparam int NUM_CHAN = SEL_W / HALF_W;

  for (genvar side = 0; side < 2; side++) begin : g_side
    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
      laneCmd_t          laneCmd;
      logic              laneTick;
      logic [HALF_W-1:0] laneSel;

      if (side == 0) begin : g_in
        assign laneSel     = selIn[ch*HALF_W +: HALF_W];
        assign tickIn[ch]  = laneTick;
      end else begin : g_out
        assign laneSel     = selOut[ch*HALF_W +: HALF_W];
        assign tickOut[ch] = laneTick;
      end

      tsel_ctrl #(
        .NUM_EXT(NUM_EXT), .NUM_BRG(NUM_BRG),
        .NUM_WS(NUM_WS),   .HALF_W(HALF_W)
      ) u_ctrl (
        .clk(clk), .sel(laneSel), .srcStrobe(srcStrobe),
        .brgStrobe(brgStrobe), .wsStrobe(wsStrobe),
        .divEn(divEn), .cmd(laneCmd)
      );

      tsel_count u_count (
        .clk(clk), .rstN(rstN), .cmd(laneCmd), .tick(laneTick)
      );
    end
  end

endmodule

// File: rtl/tsel_checks.sv
module tsel_checks #(
  parameter int NUM_EXT = 3,
  parameter int NUM_BRG = 2,
  parameter int NUM_WS  = 10,
  parameter int SEL_W   = 32,
  parameter int HALF_W  = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [SEL_W-1:0]         selIn,
  input logic [SEL_W-1:0]         selOut,
  input logic [NUM_EXT-1:0]       srcStrobe,
  input logic [NUM_BRG-1:0]       brgStrobe,
  input logic [NUM_WS-1:0]        wsStrobe,
  input logic [NUM_EXT+NUM_BRG:1] divEn,
  input logic [SEL_W/HALF_W-1:0]  tickIn,
  input logic [SEL_W/HALF_W-1:0]  tickOut
);

  // R1: outputs held low while reset is asserted
  always @(negedge clk) begin
    if (rstN === 1'b0) begin
      assert_reset_low_R1: assert (tickIn == '0 && tickOut == '0)
        else $error("tick high during reset");
    end
  end

  // R5: reserved index keeps the even input-side lane quiet
  assert_reserved_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(selIn[11:8]) <= 4'd4 && $past(selIn[4:0]) >= 5'd30) |-> !tickIn[0]);

  // R6: source code 5 gives no output
  assert_code5_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(selIn[11:8]) == 4'd5) |-> !tickIn[0]);

  // R7: disabled source never produces a tick
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(selIn[11:8]) == 4'd0 && !$past(divEn[1])) |-> !tickIn[0]);

  // R8: a change of meaningful select bits gives a low output next cycle
  assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((selOut[31:16] & 16'h0F1F) != ($past(selOut[31:16]) & 16'h0F1F)) |=> !tickOut[1]);

  // R9: a divider tick lasts one cycle
  assert_single_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn[0] && selIn[11:8] <= 4'd4) |=> !tickIn[0]);

endmodule

bind rate_timing_sel tsel_checks #(
  .NUM_EXT(NUM_EXT), .NUM_BRG(NUM_BRG), .NUM_WS(NUM_WS),
  .SEL_W(SEL_W), .HALF_W(HALF_W)
) u_chk (.*);

// File: tb/rate_timing_sel_tb.sv
module rate_timing_sel_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] selIn = '0;
  logic [31:0] selOut = '0;
  logic [2:0]  srcStrobe = '0;
  logic [1:0]  brgStrobe = '0;
  logic [9:0]  wsStrobe = '0;
  logic [5:1]  divEn = '0;
  logic [1:0]  tickIn;
  logic [1:0]  tickOut;

  int checks = 0;
  int fails  = 0;
  int cnt [4];
  logic [15:0] prevSel [4];

  always #10 clk = ~clk;   // 50 MHz

  rate_timing_sel u_dut (
    .clk(clk), .rstN(rstN), .selIn(selIn), .selOut(selOut),
    .srcStrobe(srcStrobe), .brgStrobe(brgStrobe), .wsStrobe(wsStrobe),
    .divEn(divEn), .tickIn(tickIn), .tickOut(tickOut)
  );

  // Ratio table from the requirement: 2,4,6 then 8 growing by 3/2 and 4/3
  function automatic int refRatio(int i);
    int t;
    if (i < 3) return 2 * (i + 1);
    if (i == 29) return 98304;
    if (i > 29) return 0;
    t = 8;
    for (int k = 4; k <= i; k++) t = (k % 2 == 0) ? t * 3 / 2 : t * 4 / 3;
    return t;
  endfunction

  function automatic logic [15:0] getHalf(int l);
    return (l < 2) ? selIn[l*16 +: 16] : selOut[(l-2)*16 +: 16];
  endfunction

  task automatic setHalf(int l, logic [15:0] v);
    if (l < 2) selIn[l*16 +: 16] = v;
    else       selOut[(l-2)*16 +: 16] = v;
  endtask

  function automatic logic [15:0] mkSel(int code, int idx);
    return {4'h0, 4'(code), 3'b000, 5'(idx)};
  endfunction

  // One cycle: model the expected ticks from the inputs now applied,
  // advance to the next falling edge and compare.
  task automatic step(string tag);
    logic expT [4];
    string tg [4];
    logic [4:0] clkVec;
    clkVec = {brgStrobe, srcStrobe};
    for (int l = 0; l < 4; l++) begin
      logic [15:0] m;
      int code, idx;
      m = getHalf(l) & 16'h0F1F;
      code = int'(m[11:8]);
      idx  = int'(m[4:0]);
      expT[l] = 1'b0;
      tg[l] = tag;
      if (m != prevSel[l]) begin
        cnt[l] = 0;
      end else if (code <= 4) begin
        if (idx >= 30) tg[l] = "R5";
        else if (divEn[code+1] && clkVec[code]) begin
          cnt[l]++;
          if (cnt[l] == refRatio(idx)) begin
            expT[l] = 1'b1;
            cnt[l] = 0;
          end
        end
      end else if (code >= 6) begin
        expT[l] = wsStrobe[code-6];
      end
      prevSel[l] = m;
    end
    @(negedge clk);
    for (int l = 0; l < 4; l++) begin
      logic act;
      act = (l < 2) ? tickIn[l] : tickOut[l-2];
      checks++;
      if (act !== expT[l]) begin
        fails++;
        $display("FAIL %s lane %0d: tick=%0b expected=%0b", tg[l], l, act, expT[l]);
      end
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finishRun();
  end

  initial begin
    int seed;
    seed = $urandom(32'h1357);
    // R1: reset state
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checks++;
      if (tickIn !== 2'b00 || tickOut !== 2'b00) begin
        fails++;
        $display("FAIL R1 reset: ticks=%b%b expected=0000", tickIn, tickOut);
      end
    end
    divEn = 5'b11111;
    for (int l = 0; l < 4; l++) begin
      prevSel[l] = getHalf(l) & 16'h0F1F;
      cnt[l] = 0;
    end
    rstN = 1'b1;

    // R9: ratio 2 on lane 0, strobe every cycle gives one-cycle ticks
    srcStrobe = 3'b001;
    for (int k = 0; k < 8; k++) step("R9");
    srcStrobe = 3'b000;

    // R4 and R5: sweep all indices, four lanes in parallel
    for (int b = 0; b < 8; b++) begin
      int maxR;
      maxR = 0;
      for (int l = 0; l < 4; l++) begin
        int v;
        v = 29 - (b * 4 + l);
        if (v < 0) v = v + 32;
        setHalf(l, mkSel(0, v));
        if (refRatio(v) > maxR) maxR = refRatio(v);
      end
      srcStrobe = 3'b000;
      step("R4");
      srcStrobe = 3'b001;
      for (int k = 0; k < maxR; k++) step("R4");
      srcStrobe = 3'b000;
    end

    // R2: halves and sides are independent
    selIn  = {mkSel(0, 1), mkSel(0, 0)};
    selOut = {mkSel(2, 0), mkSel(1, 0)};
    step("R2");
    srcStrobe = 3'b001;
    for (int k = 0; k < 8; k++) step("R2");
    srcStrobe = 3'b000;

    // R3: random clock sources and strobes
    for (int k = 0; k < 2000; k++) begin
      if (k % 200 == 0)
        for (int l = 0; l < 4; l++) setHalf(l, mkSel($urandom % 5, $urandom % 7));
      srcStrobe = 3'($urandom);
      brgStrobe = 2'($urandom);
      step("R3");
    end

    // R7: random enables as well
    for (int k = 0; k < 2000; k++) begin
      if (k % 250 == 0)
        for (int l = 0; l < 4; l++) setHalf(l, mkSel($urandom % 5, $urandom % 6));
      srcStrobe = 3'($urandom);
      brgStrobe = 2'($urandom);
      divEn     = 5'($urandom);
      step("R7");
    end

    // R6: word-select pass-through and code 5
    for (int k = 0; k < 1000; k++) begin
      if (k % 50 == 0)
        for (int l = 0; l < 4; l++) setHalf(l, mkSel(5 + $urandom % 11, $urandom % 32));
      wsStrobe = 10'($urandom);
      divEn    = 5'($urandom);
      step("R6");
    end
    wsStrobe = '0;
    divEn = 5'b11111;

    // R8: restart on change, strobe in the change cycle dropped, masked bits ignored
    srcStrobe = 3'b000;
    brgStrobe = 2'b00;
    setHalf(0, mkSel(0, 3));
    setHalf(1, mkSel(0, 4));
    setHalf(2, mkSel(5, 0));
    setHalf(3, mkSel(5, 0));
    step("R8");
    srcStrobe = 3'b001;
    for (int k = 0; k < 5; k++) step("R8");
    setHalf(0, mkSel(0, 4));
    setHalf(1, mkSel(0, 4) | 16'hF0E0);
    step("R8");
    for (int k = 0; k < 14; k++) step("R8");
    srcStrobe = 3'b000;
    step("R8");

    finishRun();
  end

endmodule